// File: doc/BRIEF.md
# Double-Buffered Output Compare Channel

This block is one 16-bit output compare channel of a timer. A host reaches it over an 8-bit data bus. A 16-bit compare value is assembled from two byte writes. The high byte is parked in a shared temporary register, and the low-byte write then commits both halves in a single clock edge. The committed value is compared against an external 16-bit counter on every clock. Each match sets a sticky match flag and acts on a waveform output pin.

The 4-bit waveform mode input is decoded inside the block into two classes. In the PWM class, host writes land in a shadow register. That register is copied into the active compare register only on the counter's TOP or BOTTOM strobe, and the decoded mode picks which one. This keeps a pulse from being cut short or stretched by a write in the middle of a period. In the non-PWM class, writes go straight to the active register. A force strobe can also make the pin act as if a match had occurred without touching the flag. The counter, the waveform shaping logic and interrupt routing sit outside this block.

Top module: `ocmp_channel`

## Requirements
- R1: After reset, the shadow, active and temporary registers read as zero, `wave_out` is 0 and `match_flag` is 0.
- R2: A high-byte write (`wr_hi`) loads only the temporary register. The value visible at `rd_data` and the compare value are unchanged by it.
- R3: In the non-PWM modes (mode values 0, 4 and 12), a low-byte write (`wr_lo`) stores {temporary byte, `bus_wdata`} into the active compare register at that clock edge.
- R4: In the PWM modes (every mode value except 0, 4 and 12), a low-byte write stores {temporary byte, `bus_wdata`} into the shadow register. The active compare register keeps its old value until an update strobe.
- R5: In a PWM mode, the shadow register is copied into the active register on the clock edge where the selected strobe is high. The strobe is `at_top` for mode values 1, 2, 3, 10 and 11, and `at_bottom` for 5, 6, 7, 8, 9, 13, 14 and 15. The other strobe has no effect.
- R6: When `cnt_val` equals the active compare value in a cycle, `match_flag` is 1 after that clock edge.
- R7: Holding `flag_clr` high for a cycle clears `match_flag` at that edge, unless a match happens in the same cycle, in which case the flag stays 1.
- R8: On a match, `out_mode` acts on `wave_out` at that edge. The codes are 0 = keep, 1 = toggle, 2 = drive 0 and 3 = drive 1.
- R9: In a non-PWM mode, `force_pulse` acts on `wave_out` exactly as a match would under `out_mode`, and it never sets `match_flag`.
- R10: In a PWM mode, `force_pulse` has no effect on `wave_out` or `match_flag`.
- R11: `rd_data` returns the high byte when `rd_hi_sel` is 1 and the low byte when it is 0. It reads from the shadow register in a PWM mode and from the active register otherwise. Reads never alter the temporary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Counter value from the timer |
| at_top | input | 1 | Counter is at TOP this cycle |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| wave_mode | input | 4 | Waveform mode selector |
| out_mode | input | 2 | Pin action on a match or force |
| force_pulse | input | 1 | Force-match strobe (non-PWM modes only) |
| bus_wdata | input | 8 | Host write byte |
| wr_hi | input | 1 | Write the high byte into the temporary register |
| wr_lo | input | 1 | Write the low byte and commit the 16-bit value |
| flag_clr | input | 1 | Clear the match flag (write-one strobe) |
| rd_hi_sel | input | 1 | Read byte select, 1 = high byte |
| rd_data | output | 8 | Read byte of the host-visible compare value |
| match_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Waveform output pin |

## Verification
The bench writes in a PWM mode and then keeps the counter at the old compare value. A design that bypassed the shadow register would lose the expected match or gain a wrong one. It pulses the strobe that does not apply to the current mode and checks that no copy happens, which catches a TOP/BOTTOM decode that is inverted or too broad. It raises a clear and a match in the same cycle, where a design that lets the clear win would drop the flag. It also forces the pin in both mode classes, where a wrongly gated force would either set the flag or move the pin during PWM.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef struct packed {
    logic is_pwm;
    logic upd_at_top;
  } mode_info_t;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_act_e;

  // Mode lookup: class and update point of the shadow register.
  function automatic mode_info_t decode_mode(input logic [3:0] m);
    mode_info_t r;
    case (m)
      4'd0, 4'd4, 4'd12:               r = '{is_pwm: 1'b0, upd_at_top: 1'b0};
      4'd1, 4'd2, 4'd3, 4'd10, 4'd11:  r = '{is_pwm: 1'b1, upd_at_top: 1'b1};
      default:                         r = '{is_pwm: 1'b1, upd_at_top: 1'b0};
    endcase
    return r;
  endfunction

  // Pin value after a match or force under the given action code.
  function automatic logic pin_next(input logic [1:0] com, input logic cur);
    logic r;
    case (pin_act_e'(com))
      PIN_TOGGLE: r = ~cur;
      PIN_CLEAR:  r = 1'b0;
      PIN_SET:    r = 1'b1;
      default:    r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ocmp_store.sv
module ocmp_store #(
  parameter int DATA_W = 8,
  localparam int VAL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              is_pwm,
  input  logic              upd,
  output logic [VAL_W-1:0]  shadow_q,
  output logic [VAL_W-1:0]  active_q
);

  logic [DATA_W-1:0] temp_q;
  logic [VAL_W-1:0]  wr_val;
  logic              wr_shadow;
  logic              wr_active;

  assign wr_val    = {temp_q, wdata};
  assign wr_shadow = wr_lo & is_pwm;
  assign wr_active = wr_lo & ~is_pwm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) temp_q <= '0;
    else if (wr_hi) temp_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (wr_shadow) shadow_q <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else if (upd) active_q <= shadow_q;
    else if (wr_active) active_q <= wr_val;
  end

  // R2: a high-byte write alone leaves both 16-bit registers untouched
  p_hi_only_temp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !upd) |=> ($stable(shadow_q) && $stable(active_q)));

  // R3: direct write in non-PWM modes
  p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !is_pwm) |=> (active_q == {$past(temp_q), $past(wdata)}));

  // R4: active register holds in PWM modes between update points
  p_pwm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && !upd) |=> $stable(active_q));

  // R5: the update copies the old shadow value
  p_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (active_q == $past(shadow_q)));

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] cnt_val,
  input  logic [VAL_W-1:0] cmp_val,
  input  logic             flag_clr,
  output logic             match_evt,
  output logic             flag_q
);

  assign match_evt = (cnt_val == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (match_evt) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  // R6: every match leaves the flag set
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  // R7: clear without a match drops the flag
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && flag_clr && !match_evt) |=> !flag_q);

  // R9: nothing but a real match raises the flag (force included)
  p_no_spurious_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !match_evt) |=> !flag_q);

endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin
  import ocmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_evt,
  input  logic       force_pulse,
  input  logic       is_pwm,
  input  logic [1:0] out_mode,
  output logic       pin_q
);

  logic act_evt;

  assign act_evt = match_evt | (force_pulse & ~is_pwm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else if (act_evt) pin_q <= pin_next(out_mode, pin_q);
  end

  // R8: set, clear and toggle actions
  p_pin_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_evt && out_mode == 2'd3) |=> pin_q);

  p_pin_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_evt && out_mode == 2'd2) |=> !pin_q);

  p_pin_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_evt && out_mode == 2'd1) |=> (pin_q != $past(pin_q)));

  // R10: in PWM modes only a real match can move the pin
  p_force_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && !match_evt) |=> $stable(pin_q));

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int VAL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VAL_W-1:0]  cnt_val,
  input  logic              at_top,
  input  logic              at_bottom,
  input  logic [3:0]        wave_mode,
  input  logic [1:0]        out_mode,
  input  logic              force_pulse,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              flag_clr,
  input  logic              rd_hi_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              match_flag,
  output logic              wave_out
);

  mode_info_t       minfo;
  logic             upd;
  logic             match_evt;
  logic [VAL_W-1:0] shadow_q;
  logic [VAL_W-1:0] active_q;
  logic [VAL_W-1:0] visible;

  assign minfo = decode_mode(wave_mode);
  assign upd   = minfo.is_pwm & (minfo.upd_at_top ? at_top : at_bottom);

  ocmp_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata    (bus_wdata),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .is_pwm   (minfo.is_pwm),
    .upd      (upd),
    .shadow_q (shadow_q),
    .active_q (active_q)
  );

  ocmp_match #(.VAL_W(VAL_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_val   (cnt_val),
    .cmp_val   (active_q),
    .flag_clr  (flag_clr),
    .match_evt (match_evt),
    .flag_q    (match_flag)
  );

  ocmp_pin u_pin (
    .clk         (clk),
    .rst_n       (rst_n),
    .match_evt   (match_evt),
    .force_pulse (force_pulse),
    .is_pwm      (minfo.is_pwm),
    .out_mode    (out_mode),
    .pin_q       (wave_out)
  );

  assign visible = minfo.is_pwm ? shadow_q : active_q;
  assign rd_data = rd_hi_sel ? visible[VAL_W-1:DATA_W] : visible[DATA_W-1:0];

  // R1: outputs are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!match_flag && !wave_out));

endmodule

// File: tb/test_ocmp_channel.sv
module test_ocmp_channel;

  localparam int T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = 16'hFFFF;
  logic        at_top = 1'b0, at_bottom = 1'b0;
  logic [3:0]  wave_mode = 4'd0;
  logic [1:0]  out_mode = 2'd0;
  logic        force_pulse = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0, flag_clr = 1'b0, rd_hi_sel = 1'b0;
  logic [7:0]  rd_data;
  logic        match_flag, wave_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(T/2) clk = ~clk;

  ocmp_channel i_ocmp_channel (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .at_top(at_top),
    .at_bottom(at_bottom), .wave_mode(wave_mode), .out_mode(out_mode),
    .force_pulse(force_pulse), .bus_wdata(bus_wdata), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .flag_clr(flag_clr), .rd_hi_sel(rd_hi_sel),
    .rd_data(rd_data), .match_flag(match_flag), .wave_out(wave_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, written from the requirements
  int m_temp, m_shadow, m_active;
  bit m_flag, m_pin;

  function automatic bit pwm_of(input int m);
    return !(m == 0 || m == 4 || m == 12);
  endfunction

  function automatic bit top_of(input int m);
    return (m == 1 || m == 2 || m == 3 || m == 10 || m == 11);
  endfunction

  always @(posedge clk) begin
    bit p, u, hit, act;
    int ns, na, vis;
    if (!rst_n) begin
      m_temp = 0; m_shadow = 0; m_active = 0; m_flag = 0; m_pin = 0;
    end else begin
      p   = pwm_of(int'(wave_mode));
      u   = p && (top_of(int'(wave_mode)) ? at_top : at_bottom);
      hit = (int'(cnt_val) == m_active);
      ns  = m_shadow;
      na  = m_active;
      if (wr_lo) begin
        if (p) ns = m_temp * 256 + int'(bus_wdata);
        else   na = m_temp * 256 + int'(bus_wdata);
      end
      if (u) na = m_shadow;
      if (wr_hi) m_temp = int'(bus_wdata);
      m_shadow = ns;
      m_active = na;
      m_flag = hit || (m_flag && !flag_clr);
      act = hit || (force_pulse && !p);
      if (act) begin
        case (out_mode)
          2'd1: m_pin = !m_pin;
          2'd2: m_pin = 0;
          2'd3: m_pin = 1;
          default: ;
        endcase
      end
    end
    #(T/4);
    vis = pwm_of(int'(wave_mode)) ? m_shadow : m_active;
    chk("R11 rd_data", int'(rd_data), rd_hi_sel ? vis / 256 : vis % 256);
    chk("R6 match_flag", int'(match_flag), int'(m_flag));
    chk("R8 wave_out", int'(wave_out), int'(m_pin));
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic read16(output int v);
    rd_hi_sel = 1'b0; #1; v = int'(rd_data);
    rd_hi_sel = 1'b1; #1; v = v + 256 * int'(rd_data);
    rd_hi_sel = 1'b0;
  endtask

  task automatic wr16(input logic [7:0] hi, input logic [7:0] lo);
    wr_hi = 1'b1; bus_wdata = hi; tick();
    wr_hi = 1'b0; wr_lo = 1'b1; bus_wdata = lo; tick();
    wr_lo = 1'b0;
  endtask

  task automatic clear_flag();
    cnt_val = 16'hFFFF; flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  task automatic hit_once(input logic [15:0] v);
    cnt_val = v; tick(); cnt_val = 16'hFFFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    bit pin_before;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    read16(v); chk("R1 value", v, 0);
    chk("R1 flag", int'(match_flag), 0);
    chk("R1 pin", int'(wave_out), 0);

    // R2 / R3: normal mode, two-byte write
    wave_mode = 4'd0;
    wr_hi = 1'b1; bus_wdata = 8'h12; tick(); wr_hi = 1'b0;
    read16(v); chk("R2 hi write hidden", v, 0);
    wr_lo = 1'b1; bus_wdata = 8'h34; tick(); wr_lo = 1'b0;
    read16(v); chk("R3 direct commit", v, 16'h1234);

    // R6 / R8 set
    out_mode = 2'd3; hit_once(16'h1234);
    chk("R6 flag on match", int'(match_flag), 1);
    chk("R8 set", int'(wave_out), 1);
    // R7 clear and clear-vs-match
    clear_flag(); chk("R7 clear", int'(match_flag), 0);
    flag_clr = 1'b1; cnt_val = 16'h1234; tick(); flag_clr = 1'b0; cnt_val = 16'hFFFF;
    chk("R7 match wins", int'(match_flag), 1);
    clear_flag();
    // R8 toggle, clear, keep
    out_mode = 2'd1; hit_once(16'h1234); chk("R8 toggle", int'(wave_out), 0);
    hit_once(16'h1234); chk("R8 toggle again", int'(wave_out), 1);
    out_mode = 2'd2; hit_once(16'h1234); chk("R8 clear", int'(wave_out), 0);
    out_mode = 2'd0; hit_once(16'h1234); chk("R8 keep", int'(wave_out), 0);
    clear_flag();
    // R9 force in normal mode
    out_mode = 2'd1; force_pulse = 1'b1; tick(); force_pulse = 1'b0;
    chk("R9 force pin", int'(wave_out), 1);
    chk("R9 force no flag", int'(match_flag), 0);
    wave_mode = 4'd4; out_mode = 2'd2; force_pulse = 1'b1; tick(); force_pulse = 1'b0;
    chk("R9 force ctc", int'(wave_out), 0);

    // R4 / R5: PWM mode updating at TOP
    wave_mode = 4'd1; out_mode = 2'd0;
    wr16(8'h56, 8'h78);
    read16(v); chk("R4 shadow visible", v, 16'h5678);
    hit_once(16'h1234); chk("R4 old compare active", int'(match_flag), 1);
    clear_flag();
    at_bottom = 1'b1; tick(); at_bottom = 1'b0;
    hit_once(16'h1234); chk("R5 bottom ignored in top mode", int'(match_flag), 1);
    clear_flag();
    at_top = 1'b1; tick(); at_top = 1'b0;
    hit_once(16'h5678); chk("R5 top update", int'(match_flag), 1);
    clear_flag();
    wave_mode = 4'd0; #1; read16(v); chk("R11 active visible", v, 16'h5678);

    // R5: PWM mode updating at BOTTOM
    wave_mode = 4'd14;
    wr16(8'h9A, 8'hBC);
    at_top = 1'b1; tick(); at_top = 1'b0;
    hit_once(16'h9ABC); chk("R5 top ignored in bottom mode", int'(match_flag), 0);
    at_bottom = 1'b1; tick(); at_bottom = 1'b0;
    hit_once(16'h9ABC); chk("R5 bottom update", int'(match_flag), 1);
    clear_flag();

    // R10: force ignored in PWM
    out_mode = 2'd1; pin_before = wave_out;
    force_pulse = 1'b1; tick(); force_pulse = 1'b0;
    chk("R10 pin unchanged", int'(wave_out), int'(pin_before));
    chk("R10 flag unchanged", int'(match_flag), 0);

    // R11: reads select shadow/active and leave the temporary byte alone
    wr16(8'h11, 8'h22);
    read16(v); chk("R11 pwm reads shadow", v, 16'h1122);
    wave_mode = 4'd0; #1; read16(v); chk("R11 normal reads active", v, 16'h9ABC);
    wr_hi = 1'b1; bus_wdata = 8'hAB; tick(); wr_hi = 1'b0;
    read16(v); read16(v);
    wr_lo = 1'b1; bus_wdata = 8'hCD; tick(); wr_lo = 1'b0;
    read16(v); chk("R11 reads keep temp", v, 16'hABCD);

    // Mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      wave_mode   = 4'($urandom);
      out_mode    = 2'($urandom);
      rd_hi_sel   = 1'($urandom);
      at_top      = ($urandom % 5) == 0;
      at_bottom   = ($urandom % 5) == 0;
      force_pulse = ($urandom % 6) == 0;
      wr_hi       = ($urandom % 6) == 0;
      wr_lo       = ($urandom % 6) == 0;
      flag_clr    = ($urandom % 4) == 0;
      bus_wdata   = 8'($urandom % 4);
      cnt_val     = (($urandom % 3) == 0) ? 16'(m_active) : 16'($urandom % 1024);
      tick();
    end
    wr_hi = 0; wr_lo = 0; force_pulse = 0; at_top = 0; at_bottom = 0; flag_clr = 0;
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule